// File: doc/BRIEF.md
# UART Autobaud Detector

This block sits on the raw receive line of an 8-bit, no-parity, two-stop-bit serial port. It finds the port's bit rate before any other traffic is accepted. After reset it watches for a 'U' character (55h). Because 55h is sent LSB first, the line toggles on every bit boundary. The block times the first two bit periods with the system clock, halves the result and takes that as the bit time. It then checks that every later edge of the character arrives within a quarter of a bit time of where it should. A character that fails any of these tests is dropped and the search starts over.

Once a character has passed, the block freezes the measured bit time as the divisor for the UART's transmitter and receiver. It sends a 'U' back on its transmit line at that rate. When the echo's second stop bit has ended, it raises a flag that tells the frame parser the link is open. From then until reset the receive line no longer affects the block. Parameters set the counter width, the accepted divisor range, the synchronizer depth and the rounding rule.

Top module: `abd_autobaud`

## Requirements
- R1: While reset is asserted and right after it is released, `txd` is 1, `div_valid` is 0, `comm_open` is 0 and `baud_div` is 0.
- R2: A 55h character whose bits each last P clock cycles, with MIN_DIV <= P <= MAX_DIV, sets `div_valid` to 1 and `baud_div` to P.
- R3: The span is counted from the start-bit falling edge to the next falling edge, which is the start of data bit 1. With ROUND_HALF=1 the divisor is (span+1)/2 rounded down. A start bit of P cycles followed by bits of P+1 cycles gives a span of 2P+1 and a divisor of P+1.
- R4: Each of the seven edges after the span (rising or falling) must come between B-B/4 and B+B/4 cycles after the previous edge, where B is the measured bit time and B/4 is rounded down. If all seven do, the block locks. If one comes outside that window, or none arrives by B+B/4, detection restarts and a later valid 55h locks normally.
- R5: A character other than 55h, such as 41h or 54h, does not lock the block, and a 55h sent after the line has been idle locks it.
- R6: A bit-time estimate below MIN_DIV or above MAX_DIV is rejected. A span that reaches 2*MAX_DIV+1 cycles without a falling edge is abandoned. P=MIN_DIV and P=MAX_DIV are both accepted.
- R7: On lock, `txd` sends one frame. The frame is a low start bit, then 55h LSB first (data bit 0 is 1 and the values alternate), then two high stop bits. Each bit lasts `baud_div` cycles, and `txd` is high at all other times.
- R8: `comm_open` is 0 while the echo's second stop bit is still being sent. It rises within a few cycles after that bit ends and stays 1 until reset. It is never 1 while `div_valid` is 0.
- R9: After lock, activity on `rxd` at any rate leaves `baud_div`, `div_valid` and `comm_open` unchanged and starts no further transmission on `txd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Raw serial receive line, idle high, asynchronous to clk |
| txd | output | 1 | Serial transmit line carrying the 'U' echo, idle high |
| baud_div | output | CW | Clock cycles per bit once locked, 0 before |
| div_valid | output | 1 | Divisor has been locked |
| comm_open | output | 1 | Echo finished; the link may carry frames |

## Verification
A wrong count in the span measurement shows up on `baud_div` as soon as the stop edge of the character locks the block. The same error appears one bit time later as a start bit of the wrong length on `txd`. A fault in the edge window check either blocks a lock on a valid 'U' or lets a malformed character lock. In both cases `div_valid` is wrong by the end of that character's stop bits. Faults in the echo serializer show as a wrong bit value or bit length, sampled mid-bit, within eleven bit times of lock. A premature or late `comm_open` is caught at the end of the second stop bit.

// File: rtl/abd_pkg.sv
package abd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_MEAS,
      ST_CHECK,
      ST_LOCK
   } abd_state_e;

   localparam logic [7:0] ABD_SYNC_CHAR   = 8'h55;
   localparam int         ABD_STOP_BITS   = 2;
   localparam int         ABD_CHECK_EDGES = 7;
endpackage

// File: rtl/abd_edge_sync.sv
module abd_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain[0] <= din;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         prev <= chain[STAGES-1];
      end
   end

   assign fall = prev & ~chain[STAGES-1];
   assign rise = ~prev & chain[STAGES-1];
endmodule

// File: rtl/abd_period_meas.sv
module abd_period_meas
   import abd_pkg::*;
#(
   parameter int CW         = 18,
   parameter int MIN_DIV    = 8,
   parameter int MAX_DIV    = 60000,
   parameter bit ROUND_HALF = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fall,
   input  logic          rise,
   output logic          locked,
   output logic          lock_pulse,
   output logic [CW-1:0] bit_time
);
   localparam int          EW       = $clog2(ABD_CHECK_EDGES);
   localparam logic [CW:0] SPAN_LIM = (CW+1)'(2 * MAX_DIV + 1);
   localparam logic [CW:0] MIN_W    = (CW+1)'(MIN_DIV);
   localparam logic [CW:0] MAX_W    = (CW+1)'(MAX_DIV);

   abd_state_e    st;
   logic [CW-1:0] cnt;
   logic [CW-1:0] bit_q;
   logic [EW-1:0] ecnt;
   logic [CW:0]   iv;
   logic [CW:0]   bit_est;
   logic [CW:0]   lo, hi;
   logic          range_ok, in_win;

   assign iv = {1'b0, cnt} + 1'b1;

   if (ROUND_HALF) begin : g_round
      assign bit_est = (iv + 1'b1) >> 1;
   end else begin : g_trunc
      assign bit_est = iv >> 1;
   end

   assign range_ok = (bit_est >= MIN_W) && (bit_est <= MAX_W);
   assign lo       = {1'b0, bit_q} - {3'b000, bit_q[CW-1:2]};
   assign hi       = {1'b0, bit_q} + {3'b000, bit_q[CW-1:2]};
   assign in_win   = (iv >= lo) && (iv <= hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         bit_q      <= '0;
         ecnt       <= '0;
         lock_pulse <= 1'b0;
      end else begin
         lock_pulse <= 1'b0;
         case (st)
            ST_IDLE: if (fall) begin
               cnt <= '0;
               st  <= ST_MEAS;
            end
            ST_MEAS: begin
               if (fall) begin
                  if (range_ok) begin
                     bit_q <= bit_est[CW-1:0];
                     cnt   <= '0;
                     ecnt  <= '0;
                     st    <= ST_CHECK;
                  end else begin
                     st <= ST_IDLE;
                  end
               end else if (iv >= SPAN_LIM) begin
                  st <= ST_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CHECK: begin
               if (fall || rise) begin
                  if (in_win) begin
                     cnt <= '0;
                     if (ecnt == EW'(ABD_CHECK_EDGES - 1)) begin
                        st         <= ST_LOCK;
                        lock_pulse <= 1'b1;
                     end else begin
                        ecnt <= ecnt + 1'b1;
                     end
                  end else begin
                     st <= ST_IDLE;
                  end
               end else if (iv > hi) begin
                  st <= ST_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign locked   = (st == ST_LOCK);
   assign bit_time = bit_q;
endmodule

// File: rtl/abd_echo_tx.sv
module abd_echo_tx
   import abd_pkg::*;
#(
   parameter int CW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] div,
   output logic          txd,
   output logic          done
);
   localparam int FRAME_W = 1 + 8 + ABD_STOP_BITS;
   localparam int BW      = $clog2(FRAME_W);

   logic [FRAME_W-1:0] sh;
   logic [CW-1:0]      ccnt;
   logic [BW-1:0]      bcnt;
   logic               busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         ccnt <= '0;
         bcnt <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else if (start) begin
         sh   <= {{ABD_STOP_BITS{1'b1}}, ABD_SYNC_CHAR, 1'b0};
         ccnt <= '0;
         bcnt <= '0;
         busy <= 1'b1;
      end else if (busy) begin
         if (ccnt == div - 1'b1) begin
            ccnt <= '0;
            sh   <= {1'b1, sh[FRAME_W-1:1]};
            if (bcnt == BW'(FRAME_W - 1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               bcnt <= bcnt + 1'b1;
            end
         end else begin
            ccnt <= ccnt + 1'b1;
         end
      end
   end

   assign txd = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/abd_autobaud.sv
module abd_autobaud #(
   parameter int CW          = 18,
   parameter int MIN_DIV     = 8,
   parameter int MAX_DIV     = 60000,
   parameter int SYNC_STAGES = 2,
   parameter bit ROUND_HALF  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rxd,
   output logic          txd,
   output logic [CW-1:0] baud_div,
   output logic          div_valid,
   output logic          comm_open
);
   if (MIN_DIV < 4) begin : g_bad_min
      $error("abd_autobaud: MIN_DIV must be at least 4");
   end
   if (MAX_DIV < MIN_DIV) begin : g_bad_range
      $error("abd_autobaud: MAX_DIV below MIN_DIV");
   end
   if (2 * MAX_DIV + 2 >= (1 << CW)) begin : g_bad_cw
      $error("abd_autobaud: CW too narrow for twice MAX_DIV");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("abd_autobaud: SYNC_STAGES must be at least 2");
   end

   logic          fall, rise;
   logic          locked, lock_pulse;
   logic [CW-1:0] bit_time;

   abd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rxd),
      .fall (fall),
      .rise (rise)
   );

   abd_period_meas #(
      .CW        (CW),
      .MIN_DIV   (MIN_DIV),
      .MAX_DIV   (MAX_DIV),
      .ROUND_HALF(ROUND_HALF)
   ) u_meas (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall      (fall),
      .rise      (rise),
      .locked    (locked),
      .lock_pulse(lock_pulse),
      .bit_time  (bit_time)
   );

   abd_echo_tx #(.CW(CW)) u_tx (
      .clk  (clk),
      .rst_n(rst_n),
      .start(lock_pulse),
      .div  (bit_time),
      .txd  (txd),
      .done (comm_open)
   );

   assign div_valid = locked;
   assign baud_div  = locked ? bit_time : '0;
endmodule

// File: rtl/abd_autobaud_chk.sv
module abd_autobaud_chk #(
   parameter int CW      = 18,
   parameter int MIN_DIV = 8,
   parameter int MAX_DIV = 60000
) (
   input logic          clk,
   input logic          rst_n,
   input logic          txd,
   input logic [CW-1:0] baud_div,
   input logic          div_valid,
   input logic          comm_open
);
   localparam logic [CW-1:0] MIN_C = CW'(MIN_DIV);
   localparam logic [CW-1:0] MAX_C = CW'(MAX_DIV);

   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (txd && !div_valid && !comm_open && baud_div == '0));

   a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      div_valid |=> div_valid);

   a_r6_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      div_valid |-> (baud_div >= MIN_C && baud_div <= MAX_C));

   a_r7_tx_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      !div_valid |-> txd);

   a_r8_open_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
      comm_open |-> div_valid);

   a_r8_open_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      comm_open |=> comm_open);

   a_r9_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      div_valid |=> $stable(baud_div));

   a_r9_tx_quiet_open: assert property (@(posedge clk) disable iff (!rst_n)
      comm_open |-> txd);
endmodule

bind abd_autobaud abd_autobaud_chk #(
   .CW     (CW),
   .MIN_DIV(MIN_DIV),
   .MAX_DIV(MAX_DIV)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .txd      (txd),
   .baud_div (baud_div),
   .div_valid(div_valid),
   .comm_open(comm_open)
);

// File: tb/sim_abd_autobaud.sv
module sim_abd_autobaud;
   localparam int CW   = 12;
   localparam int MIND = 8;
   localparam int MAXD = 200;
   localparam int GAP  = 3 * MAXD;
   localparam int VN   = 10;

   typedef struct packed {
      logic [7:0]  ch;
      logic [15:0] p0;
      logic [15:0] p;
      logic [15:0] p2;
      logic        lk;
      logic [15:0] dv;
      logic [3:0]  req;
   } vec_t;

   // char, start-bit length, bit length, data-bit-2 length, lock expected, divisor, requirement
   localparam vec_t VEC [VN] = '{
      '{8'h55, 16'd40,  16'd40,  16'd40,  1'b1, 16'd40,  4'd2},
      '{8'h55, 16'd8,   16'd8,   16'd8,   1'b1, 16'd8,   4'd6},
      '{8'h55, 16'd200, 16'd200, 16'd200, 1'b1, 16'd200, 4'd6},
      '{8'h55, 16'd40,  16'd41,  16'd41,  1'b1, 16'd41,  4'd3},
      '{8'h55, 16'd40,  16'd40,  16'd48,  1'b1, 16'd40,  4'd4},
      '{8'h55, 16'd40,  16'd40,  16'd60,  1'b0, 16'd0,   4'd4},
      '{8'h41, 16'd40,  16'd40,  16'd40,  1'b0, 16'd0,   4'd5},
      '{8'h55, 16'd6,   16'd6,   16'd6,   1'b0, 16'd0,   4'd6},
      '{8'h55, 16'd210, 16'd210, 16'd210, 1'b0, 16'd0,   4'd6},
      '{8'h54, 16'd40,  16'd40,  16'd40,  1'b0, 16'd0,   4'd5}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rxd = 1'b1;
   logic          txd;
   logic [CW-1:0] baud_div;
   logic          div_valid;
   logic          comm_open;
   int            n_chk = 0;
   int            n_fail = 0;
   bit            wd_hit = 1'b0;

   always #4 clk = ~clk;

   abd_autobaud #(.CW(CW), .MIN_DIV(MIND), .MAX_DIV(MAXD)) u0 (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
      .baud_div(baud_div), .div_valid(div_valid), .comm_open(comm_open)
   );

   function automatic string rtag(input int n);
      case (n)
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      rxd   = 1'b1;
      cyc(5);
      rst_n = 1'b1;
      cyc(3);
      // R1: idle outputs after reset
      chk(txd === 1'b1 && div_valid === 1'b0 && comm_open === 1'b0 && baud_div === '0,
          "R1", {txd, div_valid, comm_open}, 3'b100);
   endtask

   task automatic send_char(input logic [7:0] ch, input int p0, input int p, input int p2);
      rxd = 1'b0;
      cyc(p0);
      for (int i = 0; i < 8; i++) begin
         rxd = ch[i];
         cyc(i == 2 ? p2 : p);
      end
      rxd = 1'b1;
   endtask

   task automatic recv_echo(input int dv, input string req);
      int          waitc = 0;
      bit          seen = 1'b0;
      logic [10:0] expf = {2'b11, 8'h55, 1'b0};
      logic [10:0] got = '0;
      logic        early = 1'b0;
      while (!seen && waitc < 4 * MAXD) begin
         @(negedge clk);
         waitc++;
         if (txd === 1'b0) seen = 1'b1;
      end
      chk(seen, "R7", int'(seen), 1);
      chk(div_valid === 1'b1 && baud_div === CW'(dv), req, int'(baud_div), dv);
      for (int j = 0; j < 11; j++) begin
         cyc(j == 0 ? dv / 2 : dv);
         got[j] = txd;
         if (j == 10) early = comm_open;
      end
      chk(got === expf, "R7", int'(got), int'(expf));
      chk(early === 1'b0, "R8", int'(early), 0);
      cyc(dv / 2 + 4);
      chk(comm_open === 1'b1, "R8", int'(comm_open), 1);
   endtask

   task automatic watch_quiet(input int n, output int lows);
      lows = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (txd !== 1'b1) lows++;
      end
   endtask

   task automatic run_all();
      int lows;
      for (int v = 0; v < VN; v++) begin
         do_reset();
         send_char(VEC[v].ch, int'(VEC[v].p0), int'(VEC[v].p), int'(VEC[v].p2));
         if (VEC[v].lk) begin
            recv_echo(int'(VEC[v].dv), rtag(int'(VEC[v].req)));
         end else begin
            watch_quiet(2 * int'(VEC[v].p) + GAP, lows);
            chk(div_valid === 1'b0 && lows == 0, rtag(int'(VEC[v].req)),
                int'(div_valid) + lows, 0);
            // detection restarted: a clean 'U' now locks
            send_char(8'h55, 40, 40, 40);
            recv_echo(40, rtag(int'(VEC[v].req)));
         end
      end

      // R9: receive line ignored once the link is open
      do_reset();
      send_char(8'h55, 40, 40, 40);
      recv_echo(40, "R2");
      cyc(80);
      send_char(8'h00, 25, 25, 25);
      watch_quiet(200, lows);
      send_char(8'h55, 60, 60, 60);
      watch_quiet(GAP, lows);
      chk(lows == 0, "R9", lows, 0);
      chk(baud_div === CW'(40) && div_valid === 1'b1 && comm_open === 1'b1, "R9",
          int'(baud_div), 40);

      // R1: reset in the open state returns to idle
      rst_n = 1'b0;
      cyc(2);
      chk(txd === 1'b1 && div_valid === 1'b0 && comm_open === 1'b0 && baud_div === '0,
          "R1", int'(baud_div), 0);
      rst_n = 1'b1;
      cyc(2);
   endtask

   initial begin
      fork
         run_all();
         begin
            cyc(150000);
            wd_hit = 1'b1;
         end
      join_any
      disable fork;
      if (wd_hit) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R2: actual timeout expected completion");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule